// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block carries out one external memory access at a time over a narrow bus. The low address byte and the data byte share one bidirectional port. The high address byte has its own output. An address-latch pulse and active-low read and write strobes frame each access.

The block runs on a tick clock at twice the oscillator frequency, so one tick is half an oscillator period. Every strobe edge falls on a whole tick. A free-running bus clock output runs at one quarter of the oscillator frequency, so one bus state lasts eight ticks. Slow devices can hold the strobe low by pulling an active-low wait input. Whole bus states are added while it is low.

The core side uses a level request with address, direction and write data. The block returns a one-tick completion pulse and the read data. Before any pins move, an address decoder checks whether the address belongs to on-chip ROM, RAM or I/O. Internal addresses complete at once with a flag and cause no external activity.

Top module: `mbus_ctrl`

## Requirements
- R1: While reset is held and whenever the block is idle, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `done` is 0. `ready` is 1 when idle after reset.
- R2: `clk_out` is 1 during reset. After reset it toggles every 4 ticks, giving a period of 8 ticks, whether or not an access is running.
- R3: Counting tick k=0 as the first tick after the accepting edge: the port drives addr[7:0] from k0 to k3. `ale` is high exactly in k1 and k2. `a_hi` shows addr[15:8] from k0 until the access ends.
- R4: The strobe falls in k4, one tick after `ale` falls. With no wait it stays low for 4 ticks (k4..k7). `rd_n` is used when we=0 and `wr_n` when we=1. The two strobes are never low together.
- R5: On a write, the port drives wdata from k4 through the tick after `wr_n` rises.
- R6: On a read, the port is released from k4 on. `ad_in` is captured at the final strobe tick, the edge where `rd_n` rises. It is returned on `rdata` with `done`.
- R7: With strobe length L ticks, `done` pulses for one tick at k=5+L and `ready` returns at k=6+L. The next address therefore cannot appear earlier than 3 ticks after the strobe rises.
- R8: `wait_n` is sampled only in the last tick of each strobe window. Each low sample adds one 8-tick state to the strobe, so L = 4 + 8*W. A low `wait_n` at any other tick has no effect.
- R9: An address is internal when `ea`=1 and addr <= 1FFFh, or when addr lies in FF00h..FF9Fh. An internal request gives `done`=1 and `int_hit`=1 at k0, with no `ale`, strobe or port drive. `ready` returns at k1.
- R10: While an access runs, `ready` is 0. Changes on `req`, `we`, `addr` and `wdata` have no effect on the access in progress, including the value shown on `a_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per oscillator period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ea | input | 1 | 1 = low 8 KiB is on-chip ROM |
| ready | output | 1 | Block idle, a request is taken at the next edge |
| done | output | 1 | One-tick completion pulse |
| int_hit | output | 1 | Completion was an internal address |
| rdata | output | 8 | Data captured by the last external read |
| ad_in | input | 8 | Value seen on the shared address/data pins |
| ad_out | output | 8 | Value driven onto the shared pins |
| ad_oe | output | 1 | Output enable for the shared pins |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch pulse, the low address is latched at its falling edge |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| wait_n | input | 1 | Active-low wait request from slow devices |
| clk_out | output | 1 | Bus clock, one quarter of the oscillator frequency |

## Verification
The wait sample and the read-data capture fall on the same edge: the last tick of a strobe window decides whether to extend the strobe and, if it does not, takes the read data. The bench provokes this by holding `wait_n` low up to the sampling tick and releasing it exactly there. It presents the inverse of the expected byte on `ad_in` in every tick except the final sampling tick. A correct design returns the true byte and a strobe of exactly 4 + 8*W ticks. A capture taken one tick early or late, or taken at an extended sample, shows up as an inverted `rdata` or a wrong strobe length.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ALE  = 3'd2,
    PH_HOLD = 3'd3,
    PH_STRB = 3'd4,
    PH_POST = 3'd5,
    PH_TURN = 3'd6,
    PH_INT  = 3'd7
  } mbus_phase_e;

  // Inclusive window test used by the internal-space decoder.
  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Total strobe length in ticks for a given number of inserted states.
  function automatic int unsigned strobe_len(input int unsigned base_ticks,
                                             input int unsigned state_ticks,
                                             input int unsigned waits);
    return base_ticks + state_ticks * waits;
  endfunction

endpackage

// File: rtl/mbus_clkdiv.sv
`timescale 1ns/1ps
module mbus_clkdiv #(
  parameter int STATE_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_out
);
  localparam int HALF  = STATE_TICKS / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b1;
    end else if (cnt_q == CNT_W'(HALF - 1)) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_out = clk_q;
endmodule

// File: rtl/mbus_decode.sv
`timescale 1ns/1ps
module mbus_decode
  import mbus_pkg::*;
#(
  parameter logic [15:0] ROM_TOP = 16'h1FFF,
  parameter logic [15:0] LOC_LO  = 16'hFF00,
  parameter logic [15:0] LOC_HI  = 16'hFF9F
) (
  input  logic [15:0] addr,
  input  logic        ea,
  output logic        internal
);
  logic rom_hit, local_hit;

  assign rom_hit   = ea && in_window(addr, 16'h0000, ROM_TOP);
  assign local_hit = in_window(addr, LOC_LO, LOC_HI);
  assign internal  = rom_hit || local_hit;
endmodule

// File: rtl/mbus_seq.sv
`timescale 1ns/1ps
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int STATE_TICKS = 8,
  parameter int ALE_TICKS   = 2,
  parameter int STRB_TICKS  = 4,
  parameter int GAP_TICKS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        internal,
  input  logic        wait_n,
  input  logic [7:0]  ad_in,
  output mbus_phase_e phase,
  output logic        is_wr,
  output logic [15:0] addr_q,
  output logic [7:0]  wdata_q,
  output logic [7:0]  rdata_q,
  output logic        int_q,
  output logic        ev_accept,
  output logic        ev_capture,
  output logic        ev_wait_ext,
  output logic        ev_done
);
  localparam int CNT_W = $clog2(STATE_TICKS);

  mbus_phase_e      ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             strb_last;

  assign phase       = ph_q;
  assign strb_last   = (ph_q == PH_STRB) && (cnt_q == '0);
  assign ev_accept   = (ph_q == PH_IDLE) && req;
  assign ev_wait_ext = strb_last && !wait_n;
  assign ev_capture  = strb_last && wait_n && !is_wr;
  assign ev_done     = (ph_q == PH_INT) || ((ph_q == PH_TURN) && (cnt_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      int_q   <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          is_wr   <= we;
          int_q   <= internal;
          cnt_q   <= '0;
          ph_q    <= internal ? PH_INT : PH_ADDR;
        end
        PH_ADDR: begin
          cnt_q <= CNT_W'(ALE_TICKS - 1);
          ph_q  <= PH_ALE;
        end
        PH_ALE: begin
          if (cnt_q == '0) ph_q <= PH_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          cnt_q <= CNT_W'(STRB_TICKS - 1);
          ph_q  <= PH_STRB;
        end
        PH_STRB: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!wait_n) begin
            cnt_q <= CNT_W'(STATE_TICKS - 1);
          end else begin
            if (!is_wr) rdata_q <= ad_in;
            ph_q <= PH_POST;
          end
        end
        PH_POST: begin
          cnt_q <= CNT_W'(GAP_TICKS - 2);
          ph_q  <= PH_TURN;
        end
        PH_TURN: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_INT: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbus_pads.sv
`timescale 1ns/1ps
module mbus_pads
  import mbus_pkg::*;
(
  input  mbus_phase_e phase,
  input  logic        is_wr,
  input  logic [15:0] addr_q,
  input  logic [7:0]  wdata_q,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n
);
  logic addr_ph, strb_ph, wdat_ph;

  assign addr_ph = (phase == PH_ADDR) || (phase == PH_ALE) || (phase == PH_HOLD);
  assign strb_ph = (phase == PH_STRB);
  assign wdat_ph = is_wr && ((phase == PH_STRB) || (phase == PH_POST));

  assign ale    = (phase == PH_ALE);
  assign rd_n   = !(strb_ph && !is_wr);
  assign wr_n   = !(strb_ph && is_wr);
  assign ad_oe  = addr_ph || wdat_ph;
  assign ad_out = addr_ph ? addr_q[7:0] : (wdat_ph ? wdata_q : 8'h00);
  assign a_hi   = addr_q[15:8];
endmodule

// File: rtl/mbus_ctrl.sv
`timescale 1ns/1ps
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int          STATE_TICKS = 8,
  parameter int          ALE_TICKS   = 2,
  parameter int          STRB_TICKS  = 4,
  parameter int          GAP_TICKS   = 2,
  parameter logic [15:0] ROM_TOP     = 16'h1FFF,
  parameter logic [15:0] LOC_LO      = 16'hFF00,
  parameter logic [15:0] LOC_HI      = 16'hFF9F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        ea,
  output logic        ready,
  output logic        done,
  output logic        int_hit,
  output logic [7:0]  rdata,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  input  logic        wait_n,
  output logic        clk_out
);
  mbus_phase_e phase;
  logic        internal, is_wr, int_q;
  logic [15:0] addr_q;
  logic [7:0]  wdata_q, rdata_q;
  logic        ev_accept, ev_capture, ev_wait_ext, ev_done;

  mbus_clkdiv #(.STATE_TICKS(STATE_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .clk_out(clk_out)
  );

  mbus_decode #(.ROM_TOP(ROM_TOP), .LOC_LO(LOC_LO), .LOC_HI(LOC_HI)) u_dec (
    .addr(addr), .ea(ea), .internal(internal)
  );

  mbus_seq #(
    .STATE_TICKS(STATE_TICKS), .ALE_TICKS(ALE_TICKS),
    .STRB_TICKS(STRB_TICKS), .GAP_TICKS(GAP_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .internal(internal), .wait_n(wait_n), .ad_in(ad_in),
    .phase(phase), .is_wr(is_wr), .addr_q(addr_q), .wdata_q(wdata_q),
    .rdata_q(rdata_q), .int_q(int_q),
    .ev_accept(ev_accept), .ev_capture(ev_capture),
    .ev_wait_ext(ev_wait_ext), .ev_done(ev_done)
  );

  mbus_pads u_pads (
    .phase(phase), .is_wr(is_wr), .addr_q(addr_q), .wdata_q(wdata_q),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  assign ready   = (phase == PH_IDLE);
  assign done    = ev_done;
  assign int_hit = ev_done && int_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/mbus_ctrl_chk.sv
`timescale 1ns/1ps
module mbus_ctrl_chk #(
  parameter int HALF_TICKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       done,
  input logic       int_hit,
  input logic       ad_oe,
  input logic [7:0] a_hi,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       clk_out,
  input logic       ev_wait_ext,
  input logic       ev_done
);
  logic ck_q;
  int   run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b1;
      run_q <= 0;
    end else begin
      ck_q  <= clk_out;
      run_q <= (clk_out != ck_q) ? 1 : run_q + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (rd_n && wr_n && !ale && !ad_oe)); // R1
  AST_CLK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out != ck_q) |-> (run_q == HALF_TICKS)); // R2
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ($past(ale, 2) && !$past(ale, 3))); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe); // R3
  AST_STRB_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> (!$past(ale) && $past(ale, 2))); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (rd_n || wr_n)); // R4
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || $rose(wr_n)) |-> ad_oe); // R5
  AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R6
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |=> !ad_oe); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_WAIT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait_ext |=> (!rd_n || !wr_n)); // R8
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && int_hit) |-> (rd_n && wr_n && !ale && !ad_oe)); // R9
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n || ale) |-> $stable(a_hi)); // R10
endmodule

bind mbus_ctrl mbus_ctrl_chk #(.HALF_TICKS(STATE_TICKS / 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .int_hit(int_hit),
  .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .clk_out(clk_out), .ev_wait_ext(ev_wait_ext), .ev_done(ev_done)
);

// File: tb/mbus_ctrl_test.sv
`timescale 1ns/1ps
module mbus_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ea = 1'b0, wait_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, ad_in = '0;
  logic        ready, done, int_hit, ad_oe, ale, rd_n, wr_n, clk_out;
  logic [7:0]  rdata, ad_out, a_hi;

  int n_tests = 0, n_fail = 0, ticks = 0;

  always #2.5 clk = ~clk;

  mbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ea(ea), .ready(ready), .done(done), .int_hit(int_hit), .rdata(rdata),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .wait_n(wait_n), .clk_out(clk_out)
  );

  // {we, ea, waits[1:0], addr[15:0], wdata[7:0], read value[7:0]}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 16'h2345, 8'h00, 8'hA5},
    {1'b1, 1'b1, 2'd0, 16'h8001, 8'h3C, 8'h00},
    {1'b0, 1'b1, 2'd0, 16'h1FFF, 8'h00, 8'h11},
    {1'b0, 1'b0, 2'd0, 16'h1FFF, 8'h00, 8'h5A},
    {1'b0, 1'b1, 2'd0, 16'h2000, 8'h00, 8'h7E},
    {1'b1, 1'b0, 2'd0, 16'hFF00, 8'h44, 8'h00},
    {1'b0, 1'b0, 2'd0, 16'hFF9F, 8'h00, 8'h22},
    {1'b0, 1'b1, 2'd1, 16'hFFA0, 8'h00, 8'hC3},
    {1'b1, 1'b1, 2'd2, 16'hFEFF, 8'h96, 8'h00},
    {1'b0, 1'b0, 2'd3, 16'h0000, 8'h00, 8'h99},
    {1'b1, 1'b0, 2'd0, 16'hFF7F, 8'h01, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit bench_internal(input logic [15:0] a, input logic e);
    return (e && a < 16'h2000) || (a >= 16'hFF00 && a < 16'hFFA0);
  endfunction

  task automatic run_vec(input logic [35:0] v);
    logic       v_we, v_ea, intl;
    int         w, len, last;
    logic [15:0] v_addr;
    logic [7:0] v_wd, v_rv;
    v_we = v[35]; v_ea = v[34]; w = int'(v[33:32]);
    v_addr = v[31:16]; v_wd = v[15:8]; v_rv = v[7:0];
    intl = bench_internal(v_addr, v_ea);
    len  = 4 + 8 * w;
    last = intl ? 1 : 6 + len;
    @(negedge clk);
    chk(ready === 1'b1, "R10 ready before request", 16'(ready), 16'd1);
    req = 1'b1; we = v_we; ea = v_ea; addr = v_addr; wdata = v_wd;
    wait_n = 1'b1; ad_in = ~v_rv;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      // scramble the core inputs: the running access must ignore them (R10)
      addr = 16'hFF10; we = ~v_we; wdata = ~v_wd;
      if (k == (intl ? 0 : 5 + len)) req = 1'b0;
      // wait low until the W-th sampling tick, high from that tick on (R8)
      wait_n = (k >= 7 + 8 * w);
      ad_in  = (k == 7 + 8 * w) ? v_rv : ~v_rv;
      if (intl) begin
        chk(done === (k == 0), "R9 done", 16'(done), 16'(k == 0));
        chk(int_hit === (k == 0), "R9 int_hit", 16'(int_hit), 16'(k == 0));
        chk(!ale && rd_n && wr_n && !ad_oe, "R9 no pin activity",
            {12'h0, ale, rd_n, wr_n, ad_oe}, 16'h6);
        chk(ready === (k == 1), "R9 ready", 16'(ready), 16'(k == 1));
      end else begin
        logic e_ale, e_strb, e_oe;
        e_ale  = (k == 1 || k == 2);
        e_strb = (k >= 4 && k <= 3 + len);
        e_oe   = (k <= 3) || (v_we && k >= 4 && k <= 4 + len);
        chk(ale === e_ale, "R3 ale", 16'(ale), 16'(e_ale));
        chk(rd_n === !(e_strb && !v_we), w > 0 ? "R8 rd_n length" : "R4 rd_n",
            16'(rd_n), 16'(!(e_strb && !v_we)));
        chk(wr_n === !(e_strb && v_we), w > 0 ? "R8 wr_n length" : "R4 wr_n",
            16'(wr_n), 16'(!(e_strb && v_we)));
        chk(ad_oe === e_oe, v_we ? "R5 ad_oe" : "R6 ad_oe", 16'(ad_oe), 16'(e_oe));
        if (e_oe && k <= 3)
          chk(ad_out === v_addr[7:0], "R3 ad_out address", 16'(ad_out), 16'(v_addr[7:0]));
        else if (e_oe)
          chk(ad_out === v_wd, "R5 ad_out write data", 16'(ad_out), 16'(v_wd));
        if (k <= 5 + len)
          chk(a_hi === v_addr[15:8], "R10 a_hi held", 16'(a_hi), 16'(v_addr[15:8]));
        chk(done === (k == 5 + len), "R7 done timing", 16'(done), 16'(k == 5 + len));
        chk(ready === (k == 6 + len), "R7 ready timing", 16'(ready), 16'(k == 6 + len));
        if (k == 5 + len) begin
          chk(int_hit === 1'b0, "R10 int_hit external", 16'(int_hit), 16'd0);
          if (!v_we) chk(rdata === v_rv, "R6 rdata capture", 16'(rdata), 16'(v_rv));
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      ticks++;
      if (ticks > 100000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual %0d expected below 100000 ticks", ticks);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int run, prev, runs_ok;
    repeat (3) @(negedge clk);
    // R1 / R2: reset state
    chk(!ale && rd_n && wr_n && !ad_oe && !done, "R1 reset pins",
        {11'h0, ale, rd_n, wr_n, ad_oe, done}, 16'h0C);
    chk(clk_out === 1'b1, "R2 clk_out in reset", 16'(clk_out), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R1 ready after reset", 16'(ready), 16'd1);
    // R2: runs of exactly 4 ticks, free running
    prev = clk_out; run = 0; runs_ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_out !== prev) begin
        if (run != 0 && run != 4 && i > 4) runs_ok = 0;
        run = 1; prev = clk_out;
      end else run++;
    end
    chk(runs_ok == 1, "R2 clk_out half period", 16'(run), 16'd4);
    // main table
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R2 again while idle after traffic, and R1 idle pins
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !ad_oe, "R1 idle pins",
        {12'h0, ale, rd_n, wr_n, ad_oe}, 16'h6);
    // reset in mid-access returns to the quiet state
    run_vec({1'b1, 1'b1, 2'd0, 16'h4242, 8'h5A, 8'h00});
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'h7777; wdata = 8'hAA; ea = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(wr_n && rd_n && !ale && !ad_oe, "R1 reset mid-access",
        {12'h0, ale, rd_n, wr_n, ad_oe}, 16'h6);
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R1 ready after second reset", 16'(ready), 16'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule